// File: doc/BRIEF.md
# Two-Tier Bandwidth Regulator

This block sits in front of a shared interconnect or memory port and decides, every cycle, which of several requesters is allowed to move its data. Each requester stands for one resource-control identifier. Software gives each identifier a guaranteed share and a ceiling share, both counted in blocks of one hundredth of the port capacity. It also gives each identifier one of three priority classes. A programmable weight per class sets how the spare bandwidth is divided.

Bytes granted to each identifier are counted over fixed windows of a programmable number of cycles. The counts start again at the end of every window. While an identifier is still below its guaranteed byte budget, it is served ahead of everyone else. Once it is past the guarantee, it competes for the spare capacity through per-class deficit credits, with round-robin among identifiers of the same class. It keeps competing until it reaches its ceiling. From then on it is shut out until the next window, even if the port is idle.

The window timer is a two-state machine. In WIN_OPEN the cycle count advances. When the count reaches the second-to-last cycle, the machine moves to WIN_EDGE. WIN_EDGE lasts exactly one cycle, the last cycle of the window, and pulses the roll signal. It then returns to WIN_OPEN at count zero. An accepted window-length write forces the machine to WIN_OPEN at count zero from either state.

Top module: `bw_regulator`

## Requirements
- R1: After reset, every identifier has guarantee 1 and ceiling 0, every identifier is in class low (0), every class weight is 1, the window is WIN_DEF cycles, cfg_err is 0, and no grant is given while no request is valid.
- R2: gnt is combinational in the same cycle as the requests. It has at most one bit set, and only for a requester whose req_valid bit is high.
- R3: The byte budget of an identifier for a block count b is floor(b * window_length * BPC / MAX_BLOCKS). Usage adds the req_bytes value of every granted request.
- R4: A requesting identifier whose usage is below its guarantee budget is granted ahead of every other identifier, whatever their classes.
- R5: Among identifiers below their guarantee, grants rotate round-robin, starting after the last one served (identifier 0 first after reset). The same rotation applies within each priority class.
- R6: If the ceiling is greater than the guarantee and usage has reached the ceiling budget, the identifier gets no grant for the rest of the window, even if the port is idle. If the ceiling is less than or equal to the guarantee, no ceiling applies.
- R7: Identifiers above their guarantee and not capped are served by class. Class codes are high = 2, medium = 1, low = 0. The selected class is the highest class with a pending identifier and a non-zero credit. Each best-effort grant uses one credit. When no pending class has credit left, all credits are reloaded from the weights and the choice is made on the reloaded values. A class with weight 0 gets no best-effort grant.
- R8: A window lasts window_length cycles. On its last cycle, every usage count is replaced by the bytes granted in that cycle.
- R9: An identifier write is rejected, with the entry unchanged, if any of these holds: the guarantee is 0, the class code is 3, or the sum of all guarantees would exceed MAX_GBLK. cfg_err shows whether any write in the most recent write cycle was rejected. Weight writes are always accepted.
- R10: A window-length write below 2 is rejected and sets cfg_err. An accepted write restarts the window at cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_ID | Request pending, one bit per identifier |
| req_bytes | input | N_ID x BYTE_W | Byte count of each pending request |
| gnt | output | N_ID | One-hot grant, same cycle |
| id_we | input | 1 | Write one identifier entry |
| id_sel | input | IDW | Identifier to write |
| id_gbw | input | BLK_W | Guaranteed blocks |
| id_mbw | input | BLK_W | Ceiling blocks |
| id_prio | input | 2 | Class code: 0 low, 1 medium, 2 high |
| wt_we | input | 1 | Write a class weight |
| wt_cls | input | 2 | Class to write (0 to 2) |
| wt_val | input | WT_W | Class weight |
| win_we | input | 1 | Write window length |
| win_len | input | WIN_W | Window length in cycles |
| cfg_err | output | 1 | Last write cycle had a rejected write |

## Verification
The hardest state to reach is the ceiling shutout combined with an idle port. One identifier has to be driven past its guarantee and then up to its ceiling inside a single window. Meanwhile every other identifier stays silent, so the only thing stopping a grant is the ceiling. A directed sequence shortens the window to 20 cycles and keeps one requester asking for 16 bytes every cycle, so it crosses both budgets within three grants and then sits refused until the roll. The zero-weight class case is reached the same way: a lone low-class requester is driven past its guarantee after its class weight has been cleared. Random traffic then mixes all classes and window boundaries against a cycle-exact reference model.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        PRIO_LOW  = 2'd0,
        PRIO_MED  = 2'd1,
        PRIO_HIGH = 2'd2
    } prio_e;

    typedef enum logic {
        WIN_OPEN = 1'b0,
        WIN_EDGE = 1'b1
    } win_st_e;
endpackage

// File: rtl/bwr_rr.sv
module bwr_rr #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic [N-1:0]   mask,
    input  logic [IDW-1:0] last,
    output logic           hit,
    output logic [IDW-1:0] pick
);
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last) + k) % N;
            if (!hit && mask[j]) begin
                hit  = 1'b1;
                pick = IDW'(j);
            end
        end
    end
endmodule

// File: rtl/bwr_cfg.sv
module bwr_cfg #(
    parameter int N        = 4,
    parameter int IDW      = 2,
    parameter int BLK_W    = 8,
    parameter int WT_W     = 4,
    parameter int WIN_W    = 12,
    parameter int MAX_GBLK = 90,
    parameter int WIN_DEF  = 100
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          id_we,
    input  logic [IDW-1:0]                id_sel,
    input  logic [BLK_W-1:0]              id_gbw,
    input  logic [BLK_W-1:0]              id_mbw,
    input  logic [1:0]                    id_prio,
    input  logic                          wt_we,
    input  logic [1:0]                    wt_cls,
    input  logic [WT_W-1:0]               wt_val,
    input  logic                          win_we,
    input  logic [WIN_W-1:0]              win_len,
    output logic [N-1:0][BLK_W-1:0]       gbw_q,
    output logic [N-1:0][BLK_W-1:0]       mbw_q,
    output logic [N-1:0][1:0]             prio_q,
    output logic [bwr_pkg::NUM_CLS-1:0][WT_W-1:0] wt_q,
    output logic [WIN_W-1:0]              len_q,
    output logic                          win_ok,
    output logic                          cfg_err
);
    import bwr_pkg::*;
    localparam int SUM_W = BLK_W + IDW + 1;

    logic [SUM_W-1:0] tot, new_sum;
    logic             id_ok, any_zero;

    always_comb begin
        tot      = '0;
        any_zero = 1'b0;
        for (int i = 0; i < N; i++) begin
            tot = tot + SUM_W'(gbw_q[i]);
            if (gbw_q[i] == '0) any_zero = 1'b1;
        end
        new_sum = tot - SUM_W'(gbw_q[id_sel]) + SUM_W'(id_gbw);
        id_ok   = (id_gbw != '0) && (id_prio != 2'd3) && (new_sum <= SUM_W'(MAX_GBLK));
        win_ok  = win_we && (win_len >= WIN_W'(2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                gbw_q[i]  <= BLK_W'(1);
                mbw_q[i]  <= '0;
                prio_q[i] <= PRIO_LOW;
            end
            for (int c = 0; c < NUM_CLS; c++) wt_q[c] <= WT_W'(1);
            len_q   <= WIN_W'(WIN_DEF);
            cfg_err <= 1'b0;
        end else begin
            if (id_we && id_ok) begin
                gbw_q[id_sel]  <= id_gbw;
                mbw_q[id_sel]  <= id_mbw;
                prio_q[id_sel] <= id_prio;
            end
            if (wt_we && (wt_cls < 2'(NUM_CLS))) wt_q[wt_cls] <= wt_val;
            if (win_ok) len_q <= win_len;
            if (id_we || wt_we || win_we)
                cfg_err <= (id_we && !id_ok) || (win_we && !win_ok);
        end
    end

    AST_GBW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        !any_zero && (tot <= SUM_W'(MAX_GBLK))); // R9
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_we && !id_ok) |=> $stable(gbw_q) && $stable(prio_q)); // R9
    AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        len_q >= WIN_W'(2)); // R10
endmodule

// File: rtl/bwr_window.sv
module bwr_window #(
    parameter int WIN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] len,
    input  logic             restart,
    output logic             roll
);
    import bwr_pkg::*;

    win_st_e          st_q, st_d;
    logic [WIN_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= WIN_OPEN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (restart) begin
            st_d  = WIN_OPEN;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                WIN_OPEN: begin
                    cnt_d = cnt_q + WIN_W'(1);
                    if (cnt_q == len - WIN_W'(2)) st_d = WIN_EDGE;
                end
                WIN_EDGE: begin
                    cnt_d = '0;
                    st_d  = WIN_OPEN;
                end
            endcase
        end
    end

    always_comb roll = (st_q == WIN_EDGE);

    AST_ROLL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> !roll); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < len); // R10
endmodule

// File: rtl/bwr_meter.sv
module bwr_meter #(
    parameter int N          = 4,
    parameter int BLK_W      = 8,
    parameter int WIN_W      = 12,
    parameter int BYTE_W     = 8,
    parameter int BPC        = 8,
    parameter int MAX_BLOCKS = 100
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N-1:0][BLK_W-1:0]  gbw,
    input  logic [N-1:0][BLK_W-1:0]  mbw,
    input  logic [WIN_W-1:0]         len,
    input  logic                     roll,
    input  logic [N-1:0]             gnt,
    input  logic [N-1:0][BYTE_W-1:0] req_bytes,
    output logic [N-1:0]             under_g,
    output logic [N-1:0]             capped
);
    localparam int PROD_W = BLK_W + WIN_W + $clog2(BPC + 1) + 1;
    localparam int CW     = (PROD_W > WIN_W + BYTE_W + 1) ? PROD_W : WIN_W + BYTE_W + 1;

    logic [N-1:0][CW-1:0] use_q;
    logic [N-1:0][CW-1:0] gb, mb;

    generate
        for (genvar i = 0; i < N; i++) begin : g_id
            always_comb begin
                gb[i]      = (CW'(gbw[i]) * CW'(len) * CW'(BPC)) / CW'(MAX_BLOCKS);
                mb[i]      = (CW'(mbw[i]) * CW'(len) * CW'(BPC)) / CW'(MAX_BLOCKS);
                under_g[i] = use_q[i] < gb[i];
                capped[i]  = (mbw[i] > gbw[i]) && (use_q[i] >= mb[i]);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) use_q[i] <= '0;
                else use_q[i] <= (roll ? CW'(0) : use_q[i])
                               + (gnt[i] ? CW'(req_bytes[i]) : CW'(0));
            end

            AST_USE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
                !roll |=> use_q[i] >= $past(use_q[i])); // R8
        end
    endgenerate
endmodule

// File: rtl/bwr_arb.sv
module bwr_arb #(
    parameter int N    = 4,
    parameter int IDW  = 2,
    parameter int WT_W = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [N-1:0]                          req,
    input  logic [N-1:0]                          under_g,
    input  logic [N-1:0]                          capped,
    input  logic [N-1:0][1:0]                     prio,
    input  logic [bwr_pkg::NUM_CLS-1:0][WT_W-1:0] wt,
    output logic [N-1:0]                          gnt
);
    import bwr_pkg::*;

    logic [N-1:0]                  t1, t2;
    logic [NUM_CLS-1:0][N-1:0]     cls_mask;
    logic [NUM_CLS:0][N-1:0]       rr_mask;
    logic [NUM_CLS:0][IDW-1:0]     rr_last, rr_pick;
    logic [NUM_CLS:0]              rr_hit;
    logic [IDW-1:0]                p1_q;
    logic [NUM_CLS-1:0][IDW-1:0]   p2_q;
    logic [NUM_CLS-1:0][WT_W-1:0]  cred_q, eff;
    logic                          any_cred, be_found;
    logic [1:0]                    be_cls;

    always_comb begin
        t1 = req & under_g;
        t2 = req & ~under_g & ~capped;
        for (int c = 0; c < NUM_CLS; c++)
            for (int i = 0; i < N; i++)
                cls_mask[c][i] = t2[i] && (prio[i] == 2'(c));
    end

    generate
        for (genvar g = 0; g <= NUM_CLS; g++) begin : g_rr
            if (g == 0) begin : g_t1
                assign rr_mask[g] = t1;
                assign rr_last[g] = p1_q;
            end else begin : g_cls
                assign rr_mask[g] = cls_mask[g-1];
                assign rr_last[g] = p2_q[g-1];
            end
            bwr_rr #(.N(N), .IDW(IDW)) u_rr (
                .mask(rr_mask[g]), .last(rr_last[g]),
                .hit(rr_hit[g]), .pick(rr_pick[g])
            );
        end
    endgenerate

    always_comb begin
        any_cred = 1'b0;
        for (int c = 0; c < NUM_CLS; c++)
            if ((cls_mask[c] != '0) && (cred_q[c] != '0)) any_cred = 1'b1;
        be_found = 1'b0;
        be_cls   = 2'd0;
        for (int c = 0; c < NUM_CLS; c++) begin
            eff[c] = any_cred ? cred_q[c] : wt[c];
            if ((cls_mask[c] != '0) && (eff[c] != '0)) begin
                be_found = 1'b1;
                be_cls   = 2'(c);
            end
        end
    end

    always_comb begin
        gnt = '0;
        if (rr_hit[0]) gnt = N'(1) << rr_pick[0];
        else if (be_found) gnt = N'(1) << rr_pick[int'(be_cls) + 1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_q <= IDW'(N - 1);
            for (int c = 0; c < NUM_CLS; c++) begin
                p2_q[c]   <= IDW'(N - 1);
                cred_q[c] <= WT_W'(1);
            end
        end else if (rr_hit[0]) begin
            p1_q <= rr_pick[0];
        end else if (be_found) begin
            p2_q[be_cls] <= rr_pick[int'(be_cls) + 1];
            if (!any_cred)
                for (int c = 0; c < NUM_CLS; c++) cred_q[c] <= wt[c];
            cred_q[be_cls] <= eff[be_cls] - WT_W'(1);
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2
    AST_GNT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0); // R2
    AST_GUAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & under_g)) |-> (|(gnt & under_g))); // R4
    AST_CAP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & capped) == '0); // R6
endmodule

// File: rtl/bw_regulator.sv
module bw_regulator #(
    parameter int N_ID       = 4,
    parameter int BYTE_W     = 8,
    parameter int BLK_W      = 8,
    parameter int WT_W       = 4,
    parameter int WIN_W      = 12,
    parameter int BPC        = 8,
    parameter int MAX_BLOCKS = 100,
    parameter int MAX_GBLK   = 90,
    parameter int WIN_DEF    = 100,
    localparam int IDW       = (N_ID > 1) ? $clog2(N_ID) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_ID-1:0]             req_valid,
    input  logic [N_ID-1:0][BYTE_W-1:0] req_bytes,
    output logic [N_ID-1:0]             gnt,
    input  logic                        id_we,
    input  logic [IDW-1:0]              id_sel,
    input  logic [BLK_W-1:0]            id_gbw,
    input  logic [BLK_W-1:0]            id_mbw,
    input  logic [1:0]                  id_prio,
    input  logic                        wt_we,
    input  logic [1:0]                  wt_cls,
    input  logic [WT_W-1:0]             wt_val,
    input  logic                        win_we,
    input  logic [WIN_W-1:0]            win_len,
    output logic                        cfg_err
);
    import bwr_pkg::*;

    logic [N_ID-1:0][BLK_W-1:0]   gbw_q, mbw_q;
    logic [N_ID-1:0][1:0]         prio_q;
    logic [NUM_CLS-1:0][WT_W-1:0] wt_q;
    logic [WIN_W-1:0]             len_q;
    logic                         win_ok, roll;
    logic [N_ID-1:0]              under_g, capped;

    bwr_cfg #(.N(N_ID), .IDW(IDW), .BLK_W(BLK_W), .WT_W(WT_W), .WIN_W(WIN_W),
              .MAX_GBLK(MAX_GBLK), .WIN_DEF(WIN_DEF)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .id_we(id_we), .id_sel(id_sel), .id_gbw(id_gbw), .id_mbw(id_mbw), .id_prio(id_prio),
        .wt_we(wt_we), .wt_cls(wt_cls), .wt_val(wt_val),
        .win_we(win_we), .win_len(win_len),
        .gbw_q(gbw_q), .mbw_q(mbw_q), .prio_q(prio_q), .wt_q(wt_q), .len_q(len_q),
        .win_ok(win_ok), .cfg_err(cfg_err)
    );

    bwr_window #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .len(len_q), .restart(win_ok), .roll(roll)
    );

    bwr_meter #(.N(N_ID), .BLK_W(BLK_W), .WIN_W(WIN_W), .BYTE_W(BYTE_W),
                .BPC(BPC), .MAX_BLOCKS(MAX_BLOCKS)) u_meter (
        .clk(clk), .rst_n(rst_n), .gbw(gbw_q), .mbw(mbw_q), .len(len_q), .roll(roll),
        .gnt(gnt), .req_bytes(req_bytes), .under_g(under_g), .capped(capped)
    );

    bwr_arb #(.N(N_ID), .IDW(IDW), .WT_W(WT_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(req_valid), .under_g(under_g), .capped(capped),
        .prio(prio_q), .wt(wt_q), .gnt(gnt)
    );
endmodule

// File: tb/bw_regulator_test.sv
module bw_regulator_test;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int BPC  = 8;
    localparam int MAXB = 100;
    localparam int MAXG = 90;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [N-1:0]      req_valid = '0;
    logic [N-1:0][7:0] req_bytes = '0;
    logic [N-1:0]      gnt;
    logic       id_we = 0, wt_we = 0, win_we = 0;
    logic [1:0] id_sel = 0, id_prio = 0, wt_cls = 0;
    logic [7:0] id_gbw = 0, id_mbw = 0;
    logic [3:0] wt_val = 0;
    logic [11:0] win_len = 0;
    logic cfg_err;

    bw_regulator uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bytes(req_bytes), .gnt(gnt),
        .id_we(id_we), .id_sel(id_sel), .id_gbw(id_gbw), .id_mbw(id_mbw), .id_prio(id_prio),
        .wt_we(wt_we), .wt_cls(wt_cls), .wt_val(wt_val),
        .win_we(win_we), .win_len(win_len), .cfg_err(cfg_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // reference model state
    int m_g[N], m_m[N], m_p[N], m_use[N];
    int m_w[3], m_cred[3], m_p2[3];
    int m_len, m_cnt, m_p1, m_err;
    int e_idx, e_tier, e_cls;
    bit e_reload;

    function automatic int budget(int blk);
        return blk * m_len * BPC / MAXB;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_g[i] = 1; m_m[i] = 0; m_p[i] = 0; m_use[i] = 0;
        end
        for (int c = 0; c < 3; c++) begin
            m_w[c] = 1; m_cred[c] = 1; m_p2[c] = N - 1;
        end
        m_len = 100; m_cnt = 0; m_p1 = N - 1; m_err = 0;
    endtask

    task automatic predict();
        bit under[N], cap[N], has[3];
        bit anyc;
        int sel;
        e_idx = -1; e_tier = 0; e_cls = 0; e_reload = 0;
        for (int i = 0; i < N; i++) begin
            under[i] = m_use[i] < budget(m_g[i]);
            cap[i]   = (m_m[i] > m_g[i]) && (m_use[i] >= budget(m_m[i]));
        end
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (m_p1 + k) % N;
            if (e_idx < 0 && req_valid[j] && under[j]) e_idx = j;
        end
        if (e_idx >= 0) begin
            e_tier = 1;
            return;
        end
        anyc = 0;
        for (int c = 0; c < 3; c++) begin
            has[c] = 0;
            for (int i = 0; i < N; i++)
                if (req_valid[i] && !under[i] && !cap[i] && m_p[i] == c) has[c] = 1;
            if (has[c] && m_cred[c] > 0) anyc = 1;
        end
        sel = -1;
        for (int c = 0; c < 3; c++)
            if (has[c] && (anyc ? m_cred[c] : m_w[c]) > 0) sel = c;
        if (sel < 0) return;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (m_p2[sel] + k) % N;
            if (e_idx < 0 && req_valid[j] && !under[j] && !cap[j] && m_p[j] == sel) e_idx = j;
        end
        e_tier = 2; e_cls = sel; e_reload = !anyc;
    endtask

    task automatic model_edge();
        bit roll, bad;
        int sum;
        roll = (m_cnt == m_len - 1);
        for (int i = 0; i < N; i++) begin
            int add;
            add = (i == e_idx) ? int'(req_bytes[i]) : 0;
            m_use[i] = roll ? add : m_use[i] + add;
        end
        if (e_tier == 1) m_p1 = e_idx;
        if (e_tier == 2) begin
            if (e_reload) for (int c = 0; c < 3; c++) m_cred[c] = m_w[c];
            m_cred[e_cls] = m_cred[e_cls] - 1;
            m_p2[e_cls] = e_idx;
        end
        if (win_we && win_len >= 2) m_cnt = 0;
        else if (roll) m_cnt = 0;
        else m_cnt = m_cnt + 1;
        bad = 0;
        if (id_we) begin
            sum = 0;
            for (int i = 0; i < N; i++) if (i != id_sel) sum += m_g[i];
            sum += id_gbw;
            if (id_gbw != 0 && id_prio != 3 && sum <= MAXG) begin
                m_g[id_sel] = id_gbw; m_m[id_sel] = id_mbw; m_p[id_sel] = id_prio;
            end else bad = 1;
        end
        if (wt_we && wt_cls < 3) m_w[wt_cls] = wt_val;
        if (win_we) begin
            if (win_len >= 2) m_len = win_len;
            else bad = 1;
        end
        if (id_we || wt_we || win_we) m_err = bad;
    endtask

    task automatic check(string tag, int act, int exp, string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // called at a negedge with inputs already driven; returns at the next negedge
    task automatic step(string tag);
        int expg;
        #1;
        predict();
        expg = (e_idx >= 0) ? (1 << e_idx) : 0;
        check(tag, int'(gnt), expg, "gnt");
        @(posedge clk);
        model_edge();
        @(negedge clk);
        id_we = 0; wt_we = 0; win_we = 0;
    endtask

    task automatic wr_id(int sel, int g, int m, int p, string tag);
        id_we = 1; id_sel = 2'(sel); id_gbw = 8'(g); id_mbw = 8'(m); id_prio = 2'(p);
        step(tag);
        check(tag, int'(cfg_err), m_err, "cfg_err");
    endtask

    task automatic wr_wt(int c, int v, string tag);
        wt_we = 1; wt_cls = 2'(c); wt_val = 4'(v);
        step(tag);
        check(tag, int'(cfg_err), m_err, "cfg_err");
    endtask

    task automatic wr_win(int l, string tag);
        win_we = 1; win_len = 12'(l);
        step(tag);
        check(tag, int'(cfg_err), m_err, "cfg_err");
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20231));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state, no request -> no grant, no error
        step("R1");
        check("R1", int'(cfg_err), 0, "cfg_err after reset");
        // R1 R5: defaults, everyone below guarantee, rotation from id 0
        req_valid = 4'hF;
        for (int i = 0; i < N; i++) req_bytes[i] = 8'd3;
        repeat (6) step("R1 R5");
        req_valid = 0;
        // R9: rejected identifier writes
        wr_id(0, 0, 5, 2, "R9");
        check("R9", int'(cfg_err), 1, "zero guarantee rejected");
        wr_id(0, 89, 5, 2, "R9");
        check("R9", int'(cfg_err), 1, "sum limit rejected");
        wr_id(1, 5, 5, 3, "R9");
        check("R9", int'(cfg_err), 1, "class 3 rejected");
        wr_id(0, 10, 30, 2, "R9");
        check("R9", int'(cfg_err), 0, "legal write accepted");
        // R10: window length
        wr_win(1, "R10");
        check("R10", int'(cfg_err), 1, "length 1 rejected");
        wr_wt(2, 2, "R9");
        check("R9", int'(cfg_err), 0, "weight write clears error");
        wr_win(20, "R10");
        wr_id(1, 5, 0, 0, "R9");
        wr_id(2, 20, 40, 1, "R9");
        wr_id(3, 1, 50, 0, "R9");
        wr_wt(1, 1, "R7");
        wr_wt(0, 3, "R7");
        // R6: lone requester runs into its ceiling with an idle port
        req_valid = 4'b0001; req_bytes[0] = 8'd16;
        for (int c = 0; c < 24; c++) step("R6 R3 R8");
        req_valid = 0;
        // R7: zero weight class starves after guarantee
        wr_wt(0, 0, "R7");
        req_valid = 4'b0010; req_bytes[1] = 8'd8;
        for (int c = 0; c < 24; c++) step("R7");
        req_valid = 0;
        wr_wt(0, 3, "R7");
        // R4 R7: guarantee beats class
        req_valid = 4'b1101; req_bytes = {8'd9, 8'd9, 8'd9, 8'd9};
        for (int c = 0; c < 30; c++) step("R4 R7");
        // random mix
        for (int c = 0; c < 4000; c++) begin
            req_valid = 4'($urandom % 16);
            for (int i = 0; i < N; i++) req_bytes[i] = 8'(1 + $urandom % 16);
            if ($urandom % 500 == 0) begin
                win_we = 1; win_len = 12'(2 + $urandom % 30);
            end
            step("R2 R3 R4 R5 R6 R7 R8 R10");
        end
        req_valid = 0;
        step("R2");
        summary();
    end
endmodule